// File: doc/BRIEF.md
# Serial Register Bus Read Engine

This block is the processor-facing read path of a serial bus controller that reaches registers inside a companion power-management chip. Software writes a target register address into a command register. That single write launches one read transaction; there is no separate start bit. The engine then issues one request to a serializer and waits for its reply. While the transaction is in flight, a busy flag is visible to software.

When the reply arrives, the engine packs the busy flag, the echoed target address and the 16-bit returned value into one status word. Software polls that word until busy drops, then compares the echoed address with the one it asked for before it uses the data. A control register selects how many address bits go onto the link and come back in the echo. The value 0 selects the 12-bit default.

The serializer side is a valid/ready request channel and a valid-only response channel. The request holds valid and its address steady until ready is seen, so the serializer may stall it for any number of cycles. Only one transaction is ever outstanding, so the engine accepts the response pulse unconditionally and there is no response back-pressure. A response pulse that arrives when no request has been handed over is ignored.

Top module: `sbus_read_engine`

## Requirements
- R1: A write to offset 0x28 while the engine is idle starts a transaction, and `req_valid` is 1 from the cycle after that write.
- R2: The busy flag (bit 31 of offset 0x2c) reads 1 from the same clock edge that accepts the command write.
- R3: The busy flag stays 1 until the clock edge that takes the response, and it reads 0 after that edge.
- R4: After a completed read, bits 15:0 of offset 0x2c hold the 16-bit value carried by `rsp_data`.
- R5: After a completed read, bits 30:16 of offset 0x2c hold the address that was sent on `req_addr` for that read.
- R6: Bit 0 of offset 0x04 selects the address width and reads back its value, which is 0 after reset. With 0, only bits 11:0 of the command write are sent and echoed, and bits 14:12 are zero. With 1, bits 14:0 are used. The width is sampled when the command is accepted.
- R7: A command write while busy is 1 is ignored, including a write in the same cycle as the completing response. No new request follows, and the pending address is unchanged.
- R8: Offset 0x2c keeps the last completed result until the next read completes. A `rsp_valid` pulse while no request is outstanding is ignored.
- R9: `req_valid` stays 1 and `req_addr` stays stable until `req_ready` is seen. A response is taken only after that handshake.
- R10: After reset, offset 0x2c reads 0 and `req_valid` is 0. Reads of any offset other than 0x04 and 0x2c return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| req_valid | output | 1 | Request to the serializer is valid |
| req_ready | input | 1 | Serializer accepts the request |
| req_addr | output | 15 | Target register address of the request |
| rsp_valid | input | 1 | Single-cycle response pulse |
| rsp_data | input | 16 | Returned register value |

## Verification
The case that matters most is a new command write landing in the same cycle as the response that finishes the current read. The bench watches the responder's pulse and puts a command write into exactly that cycle. The expected outcome is that busy clears, the result shows the old address and data, and no new request appears. A second overlap is request back-pressure, where a stall coincides with a stray response pulse or a second command. A behavioural model compares the status word, `req_valid` and `req_addr` on every clock.

// File: rtl/sbus_rd_pkg.sv
package sbus_rd_pkg;
  localparam int BUS_AW   = 8;
  localparam int BUS_DW   = 32;
  localparam int SHORT_AW = 12;
  localparam int LONG_AW  = 15;
  localparam int VAL_W    = 16;
  localparam logic [BUS_AW-1:0] OFS_WIDTH = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_CMD   = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h2c;
  typedef enum logic [1:0] {ENG_IDLE = 2'd0, ENG_REQ = 2'd1, ENG_WAIT = 2'd2} eng_state_t;
endpackage

// File: rtl/sbus_rd_regs.sv
module sbus_rd_regs
  import sbus_rd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  output logic               cmd_strobe,
  output logic [LONG_AW-1:0] cmd_addr,
  input  logic               busy,
  input  logic [LONG_AW-1:0] res_echo,
  input  logic [VAL_W-1:0]   res_data
);
  localparam int HI_W = LONG_AW - SHORT_AW;

  logic wide_mode;
  logic unused_wbits;
  assign unused_wbits = ^bus_wdata[BUS_DW-1:LONG_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_mode <= 1'b0;
    else if (bus_we && bus_addr == OFS_WIDTH) wide_mode <= bus_wdata[0];
  end

  assign cmd_strobe = bus_we && (bus_addr == OFS_CMD);

  // Narrow mode zeroes the bits above the short address width.
  always_comb begin
    cmd_addr = bus_wdata[LONG_AW-1:0];
    if (!wide_mode) cmd_addr[LONG_AW-1:SHORT_AW] = {HI_W{1'b0}};
  end

  always_comb begin
    unique case (bus_addr)
      OFS_WIDTH: bus_rdata = {{(BUS_DW-1){1'b0}}, wide_mode};
      OFS_STAT:  bus_rdata = {busy, res_echo, res_data};
      default:   bus_rdata = '0;
    endcase
  end

  // R6: the width field takes the written bit on the next edge
  a_r6_width_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_WIDTH) |=> (wide_mode == $past(bus_wdata[0])));
endmodule

// File: rtl/sbus_rd_engine.sv
module sbus_rd_engine
  import sbus_rd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_strobe,
  input  logic [LONG_AW-1:0] cmd_addr,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [LONG_AW-1:0] req_addr,
  input  logic               rsp_valid,
  input  logic [VAL_W-1:0]   rsp_data,
  output logic               busy,
  output logic [LONG_AW-1:0] res_echo,
  output logic [VAL_W-1:0]   res_data
);
  eng_state_t state;
  logic [LONG_AW-1:0] pend_addr;
  logic accept, done;

  assign accept = cmd_strobe && (state == ENG_IDLE);
  assign done   = rsp_valid && (state == ENG_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      pend_addr <= '0;
      res_echo  <= '0;
      res_data  <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (accept) begin
          state     <= ENG_REQ;
          pend_addr <= cmd_addr;
        end
        ENG_REQ:  if (req_ready) state <= ENG_WAIT;
        ENG_WAIT: if (done) begin
          state    <= ENG_IDLE;
          res_echo <= pend_addr;
          res_data <= rsp_data;
        end
        default:  state <= ENG_IDLE;
      endcase
    end
  end

  assign busy      = (state != ENG_IDLE);
  assign req_valid = (state == ENG_REQ);
  assign req_addr  = pend_addr;

  // R2: an accepted command shows busy right after its edge
  a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && !busy) |=> busy);
  // R3: busy only drops through a taken response
  a_r3_busy_until_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> busy);
  // R7: a command while busy leaves the pending address alone
  a_r7_ignore_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_strobe) |=> $stable(pend_addr));
  // R8: result is held unless a read finishes
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && !req_valid && rsp_valid) |=> ($stable(res_data) && $stable(res_echo)));
  // R9: request held until ready
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
endmodule

// File: rtl/sbus_read_engine.sv
module sbus_read_engine
  import sbus_rd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [14:0]         req_addr,
  input  logic                rsp_valid,
  input  logic [15:0]         rsp_data
);
  logic               cmd_strobe;
  logic [LONG_AW-1:0] cmd_addr;
  logic               busy;
  logic [LONG_AW-1:0] res_echo;
  logic [VAL_W-1:0]   res_data;

  sbus_rd_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr),
    .busy(busy), .res_echo(res_echo), .res_data(res_data)
  );

  sbus_rd_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .res_echo(res_echo), .res_data(res_data)
  );

  // R1: an accepted command is followed by a request
  a_r1_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CMD && !busy) |=> req_valid);
endmodule

// File: tb/sbus_read_engine_bench.sv
module sbus_read_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h2c;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic req_valid, req_ready = 1'b1;
  logic [14:0] req_addr;
  logic rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;

  always #10 clk = ~clk;

  sbus_read_engine u_sbus_read_engine (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  bit m_busy, m_wait, m_wide;
  logic [14:0] m_addr, m_echo;
  logic [15:0] m_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_wide = 0; m_addr = '0; m_echo = '0; m_data = '0;
    end else begin
      bit o_busy, o_wait, o_wide;
      o_busy = m_busy; o_wait = m_wait; o_wide = m_wide;
      if (bus_we && bus_addr == 8'h04) m_wide = bus_wdata[0];
      if (o_busy && o_wait && rsp_valid) begin
        m_busy = 0; m_wait = 0; m_echo = m_addr; m_data = rsp_data;
      end
      if (o_busy && !o_wait && req_ready) m_wait = 1;
      if (bus_we && bus_addr == 8'h28 && !o_busy) begin
        m_busy = 1; m_wait = 0;
        m_addr = o_wide ? bus_wdata[14:0] : {3'b000, bus_wdata[11:0]};
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [31:0] e;
    chk("R1 req_valid", {31'd0, req_valid}, {31'd0, m_busy && !m_wait});
    chk("R9 req_addr", {17'd0, req_addr}, {17'd0, m_addr});
    if (bus_addr == 8'h2c) begin
      chk("R3 busy", {31'd0, bus_rdata[31]}, {31'd0, m_busy});
      chk("R5 echo", {17'd0, bus_rdata[30:16]}, {17'd0, m_echo});
      chk("R4 data", {16'd0, bus_rdata[15:0]}, {16'd0, m_data});
    end else begin
      e = (bus_addr == 8'h04) ? {31'd0, m_wide} : 32'd0;
      chk("R10 other offset / R6 width", bus_rdata, e);
    end
  endtask

  // behavioural responder
  int lat = 2, stall = 0, r_cnt = 0;
  bit inject = 0;
  logic [14:0] r_addr;

  function automatic logic [15:0] resp_of(logic [14:0] a);
    return {a[3:0], ~a[11:0]} ^ {1'b0, a};
  endfunction

  task automatic respond();
    rsp_valid = 0;
    if (inject) begin rsp_valid = 1; rsp_data = 16'hdead; inject = 0; end
    if (r_cnt > 0) begin
      r_cnt--;
      if (r_cnt == 0) begin rsp_valid = 1; rsp_data = resp_of(r_addr); end
    end
    if (req_valid && stall > 0) begin stall--; req_ready = 0; end
    else req_ready = 1;
    if (req_valid && req_ready) begin r_addr = req_addr; r_cnt = lat; end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    respond();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 0; bus_addr = 8'h2c;
    #1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && m_busy; i++) cyc();
  endtask

  initial begin
    repeat (3) cyc();
    chk("R10 reset status", bus_rdata, 32'd0);
    chk("R10 reset req_valid", {31'd0, req_valid}, 32'd0);
    rst_n = 1;
    cyc();

    // basic 12-bit read
    wr(8'h28, 32'hffff_7abc);
    chk("R2 busy at accept", {31'd0, bus_rdata[31]}, 32'd1);
    cyc();
    chk("R6 narrow req_addr", {17'd0, req_addr}, 32'h0abc);
    wait_idle(); cyc();
    chk("R5 echo narrow", {17'd0, bus_rdata[30:16]}, 32'h0abc);
    chk("R4 data", {16'd0, bus_rdata[15:0]}, {16'd0, resp_of(15'h0abc)});

    // wide mode
    wr(8'h04, 32'h1);
    bus_addr = 8'h04; #1;
    chk("R6 width readback", bus_rdata, 32'h1);
    bus_addr = 8'h2c;
    wr(8'h28, 32'h0000_5123);
    cyc();
    chk("R6 wide req_addr", {17'd0, req_addr}, 32'h5123);
    wait_idle(); cyc();

    // back-pressure with a stray pulse during the stall
    stall = 4;
    wr(8'h28, 32'h0000_1111);
    cyc(); inject = 1; cyc(); cyc();
    chk("R9 held under stall", {31'd0, req_valid}, 32'd1);
    wait_idle(); cyc();
    chk("R8 stray in REQ ignored", {16'd0, bus_rdata[15:0]}, {16'd0, resp_of(15'h1111)});

    // second command while busy
    wr(8'h28, 32'h0000_2222);
    wr(8'h28, 32'h0000_3333);
    chk("R7 pending kept", {17'd0, req_addr}, 32'h2222);
    wait_idle(); cyc();
    chk("R7 echo first", {17'd0, bus_rdata[30:16]}, 32'h2222);

    // command in the completing cycle
    lat = 4;
    wr(8'h28, 32'h0000_4444);
    for (int i = 0; i < 20 && !rsp_valid; i++) cyc();
    wr(8'h28, 32'h0000_0555);
    chk("R7 collision busy clear", {31'd0, bus_rdata[31]}, 32'd0);
    chk("R7 collision echo", {17'd0, bus_rdata[30:16]}, 32'h4444);
    cyc(); cyc();
    chk("R7 collision no request", {31'd0, req_valid}, 32'd0);

    // stray pulse while idle
    inject = 1; cyc(); cyc(); cyc();
    chk("R8 stray idle ignored", {16'd0, bus_rdata[15:0]}, {16'd0, resp_of(15'h4444)});

    // narrow again, several patterns
    wr(8'h04, 32'h0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = 32'h9e37_79b9 * (k + 1);
      lat = 1 + (k % 3); stall = k % 4;
      wr(8'h28, a);
      wait_idle(); cyc();
      chk("R5 echo loop", {17'd0, bus_rdata[30:16]}, {20'd0, a[11:0]});
      chk("R4 data loop", {16'd0, bus_rdata[15:0]}, {16'd0, resp_of({3'b0, a[11:0]})});
    end
    repeat (3) cyc();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule